// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the software-visible state of a four-channel DMA controller and is reached over an 8-bit I/O bus. Each channel keeps a 16-bit current address, a 16-bit current count, base copies of both, a packed mode setting and a mask bit. The 16-bit registers sit behind 8-bit ports. A byte pointer that all channels share decides whether an access reaches the low byte or the high byte, and software returns it to the low byte through a dedicated clear port.

The block also has a per-channel step input. Each step pulse on a channel that is enabled advances that channel's address and count. When the count passes zero, the channel raises terminal count. It then either reloads from its base copies or masks itself, depending on its auto-initialise setting. Arbitration, request handshakes, page extension and data movement are handled outside the block.

Port numbers on `io_addr`: channel n's address port is 2n and its count port is 2n+1 (0 to 7). The single-mask port is 8, the mode port is 9 and the pointer-clear port is 10. Reading any other port returns 0.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset, `chan_mask` is all ones and `chan_dir`, `chan_autoinit` and `chan_cascade` are zero. All address and count registers are zero and the byte pointer selects the low byte.
- R2: Every read or write of ports 0 to 7 toggles one byte pointer shared by all channels, low byte first. Reads and writes use the same pointer. Accesses to other ports leave it unchanged, and reads of those ports return 0.
- R3: A write of any data value to port 10 returns the byte pointer to the low byte.
- R4: A write to an address port loads the selected byte of both the current address and its base copy. A read returns the selected byte of the current address, so 0x55 then 0xAA written after a clear read back as 0x55 then 0xAA.
- R5: A write to a count port loads the selected byte of the current count and its base copy. Software programs length minus one. A read returns the raw current count, which is the remaining transfers minus one.
- R6: A port 8 write uses data bits 1:0 as the channel. Bit 2 = 1 sets that channel's mask and bit 2 = 0 clears it.
- R7: A port 9 write uses data bits 1:0 as the channel, bits 3:2 as the direction (01 device to memory, 10 memory to device, shown on `chan_dir[2n+1:2n]`), bit 4 as auto-initialise and bits 7:6 as the kind. Kind 11 is cascade: `chan_cascade` goes high and step pulses have no effect on that channel.
- R8: A step pulse on a channel that is unmasked and not in cascade increments its current address and decrements its current count, visible the next cycle. A step pulse on a masked channel changes nothing.
- R9: A step pulse taken while the count is 0x0000 raises that channel's `chan_tc` for exactly the next cycle. Without auto-initialise, the count wraps to 0xFFFF, the address increments and the channel masks itself.
- R10: At terminal count with auto-initialise set, the current address and count reload from their base copies and the channel stays unmasked.
- R11: A step pulse in the same cycle as a bus write to that channel's address or count port is dropped. A terminal-count self-mask overrides an unmask write to port 8 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | I/O port number |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while io_rd is high |
| step | input | 4 | Per-channel transfer step pulse |
| chan_mask | output | 4 | Per-channel mask state |
| chan_tc | output | 4 | Per-channel terminal-count pulse |
| chan_dir | output | 8 | Two direction bits per channel |
| chan_autoinit | output | 4 | Per-channel auto-initialise setting |
| chan_cascade | output | 4 | Channel is in cascade mode |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a step pulse landing in the cycle a byte is written to the same channel. The other is a terminal count landing in the cycle software unmasks the channel. The bench drives the bus strobe and the step input together at one falling edge to create each collision. It then reads the registers back through the byte pointer after clearing it. The shared pointer is checked by interleaving accesses to two channels, and by reading a port that must not advance it.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int CHANNELS   = 4;
    localparam int PORT_BITS  = 4;
    localparam int MASK_PORT  = 8;
    localparam int MODE_PORT  = 9;
    localparam int CLEAR_PORT = 10;

    typedef enum logic [1:0] {
        KIND_DEMAND  = 2'b00,
        KIND_SINGLE  = 2'b01,
        KIND_BLOCK   = 2'b10,
        KIND_CASCADE = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        DIR_CHECK    = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_RSVD     = 2'b11
    } dir_e;

    typedef struct packed {
        kind_e kind;
        logic  autoinit;
        dir_e  dir;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [7:0] b);
        mode_t m;
        m.kind     = kind_e'(b[7:6]);
        m.autoinit = b[4];
        m.dir      = dir_e'(b[3:2]);
        return m;
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic access,
    output logic hi_sel
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hi_sel <= 1'b0;
        end else if (access) begin
            hi_sel <= ~hi_sel;
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_regs_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_count,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  mode_t             mode_in,
    input  logic              mask_we,
    input  logic              mask_val,
    input  logic              step,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_count,
    output mode_t             mode,
    output logic              masked,
    output logic              tc
);
    logic [REG_W-1:0] base_addr;
    logic [REG_W-1:0] base_count;
    logic active, at_zero, reload, self_mask;

    function automatic logic [REG_W-1:0] put_byte(
        input logic [REG_W-1:0]  old,
        input logic [BYTE_W-1:0] b,
        input logic              hi
    );
        logic [REG_W-1:0] r;
        r = old;
        if (hi) r[REG_W-1 -: BYTE_W] = b;
        else    r[BYTE_W-1:0]       = b;
        return r;
    endfunction

    always_comb begin
        active    = step && !masked && (mode.kind != KIND_CASCADE) && !wr_addr && !wr_count;
        at_zero   = (cur_count == '0);
        reload    = active && at_zero && mode.autoinit;
        self_mask = active && at_zero && !mode.autoinit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            cur_count  <= '0;
            base_addr  <= '0;
            base_count <= '0;
            mode       <= '0;
            masked     <= 1'b1;
            tc         <= 1'b0;
        end else begin
            tc <= active && at_zero;

            if (wr_addr) begin
                cur_addr  <= put_byte(cur_addr, wdata, hi_sel);
                base_addr <= put_byte(base_addr, wdata, hi_sel);
            end else if (reload) begin
                cur_addr <= base_addr;
            end else if (active) begin
                cur_addr <= cur_addr + REG_W'(1);
            end

            if (wr_count) begin
                cur_count  <= put_byte(cur_count, wdata, hi_sel);
                base_count <= put_byte(base_count, wdata, hi_sel);
            end else if (reload) begin
                cur_count <= base_count;
            end else if (active) begin
                cur_count <= cur_count - REG_W'(1);
            end

            if (mode_we) begin
                mode <= mode_in;
            end

            if (self_mask) begin
                masked <= 1'b1;
            end else if (mask_we) begin
                masked <= mask_val;
            end
        end
    end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux #(
    parameter int CH_N   = 4,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8,
    localparam int CH_W  = $clog2(CH_N)
) (
    input  logic                    rd_en,
    input  logic [CH_W:0]           port,
    input  logic                    hi_sel,
    input  logic [CH_N*REG_W-1:0]   addr_bus,
    input  logic [CH_N*REG_W-1:0]   count_bus,
    output logic [BYTE_W-1:0]       rdata
);
    logic [CH_W-1:0]  sel;
    logic [REG_W-1:0] word;

    always_comb begin
        sel  = port[CH_W:1];
        word = port[0] ? count_bus[sel*REG_W +: REG_W] : addr_bus[sel*REG_W +: REG_W];
        if (!rd_en)      rdata = '0;
        else if (hi_sel) rdata = word[REG_W-1 -: BYTE_W];
        else             rdata = word[BYTE_W-1:0];
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int CH_N   = CHANNELS,
    parameter int PORT_W = PORT_BITS,
    parameter int BYTE_W = 8,
    parameter int REG_W  = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PORT_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [BYTE_W-1:0]   io_wdata,
    output logic [BYTE_W-1:0]   io_rdata,
    input  logic [CH_N-1:0]     step,
    output logic [CH_N-1:0]     chan_mask,
    output logic [CH_N-1:0]     chan_tc,
    output logic [2*CH_N-1:0]   chan_dir,
    output logic [CH_N-1:0]     chan_autoinit,
    output logic [CH_N-1:0]     chan_cascade
);
    localparam int CH_W      = $clog2(CH_N);
    localparam int REG_PORTS = 2 * CH_N;

    logic                  reg_port, reg_access, clr_hit, mask_hit, mode_hit;
    logic                  hi_sel;
    logic [CH_W-1:0]       port_ch, mask_ch, mode_ch;
    mode_t                 mode_in;
    logic [CH_N*REG_W-1:0] addr_bus, count_bus;

    always_comb begin
        reg_port   = (io_addr < PORT_W'(REG_PORTS));
        reg_access = (io_wr || io_rd) && reg_port;
        clr_hit    = io_wr && (io_addr == PORT_W'(CLEAR_PORT));
        mask_hit   = io_wr && (io_addr == PORT_W'(MASK_PORT));
        mode_hit   = io_wr && (io_addr == PORT_W'(MODE_PORT));
        port_ch    = io_addr[CH_W:1];
        mask_ch    = io_wdata[CH_W-1:0];
        mode_ch    = io_wdata[CH_W-1:0];
        mode_in    = unpack_mode(io_wdata);
    end

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clear  (clr_hit),
        .access (reg_access),
        .hi_sel (hi_sel)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        logic [REG_W-1:0] c_addr, c_count;
        mode_t            c_mode;
        logic             hit;

        assign hit = io_wr && reg_port && (port_ch == CH_W'(i));

        dma_chan #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (hit && !io_addr[0]),
            .wr_count  (hit && io_addr[0]),
            .hi_sel    (hi_sel),
            .wdata     (io_wdata),
            .mode_we   (mode_hit && (mode_ch == CH_W'(i))),
            .mode_in   (mode_in),
            .mask_we   (mask_hit && (mask_ch == CH_W'(i))),
            .mask_val  (io_wdata[CH_W]),
            .step      (step[i]),
            .cur_addr  (c_addr),
            .cur_count (c_count),
            .mode      (c_mode),
            .masked    (chan_mask[i]),
            .tc        (chan_tc[i])
        );

        assign addr_bus[i*REG_W +: REG_W]  = c_addr;
        assign count_bus[i*REG_W +: REG_W] = c_count;
        assign chan_dir[2*i +: 2]          = c_mode.dir;
        assign chan_autoinit[i]            = c_mode.autoinit;
        assign chan_cascade[i]             = (c_mode.kind == KIND_CASCADE);
    end

    dma_rd_mux #(.CH_N(CH_N), .REG_W(REG_W), .BYTE_W(BYTE_W)) u_rd (
        .rd_en     (io_rd && reg_port),
        .port      (io_addr[CH_W:0]),
        .hi_sel    (hi_sel),
        .addr_bus  (addr_bus),
        .count_bus (count_bus),
        .rdata     (io_rdata)
    );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
    import dma_regs_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [PORT_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [CH_N-1:0]   step,
    input logic [CH_N-1:0]   chan_mask,
    input logic [CH_N-1:0]   chan_tc,
    input logic [2*CH_N-1:0] chan_dir,
    input logic [CH_N-1:0]   chan_autoinit,
    input logic [CH_N-1:0]   chan_cascade,
    input logic              hi_sel
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_mask == '1 && chan_dir == '0 && chan_autoinit == '0 && chan_cascade == '0 && !hi_sel)); // R1

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ($past((io_wr || io_rd) && io_addr < PORT_W'(2*CH_N)) && !$past(rst)) |-> (hi_sel != $past(hi_sel))); // R2

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(io_wr && io_addr == PORT_W'(CLEAR_PORT)) |-> !hi_sel); // R3

    AST_NO_TC_MASKED: assert property (@(posedge clk) disable iff (rst)
        (chan_tc & $past(chan_mask)) == '0); // R8

    AST_NO_TC_CASCADE: assert property (@(posedge clk) disable iff (rst)
        (chan_tc & $past(chan_cascade)) == '0); // R7

    AST_TC_FROM_STEP: assert property (@(posedge clk) disable iff (rst)
        (chan_tc & ~$past(step)) == '0); // R9

    AST_SELF_MASK: assert property (@(posedge clk) disable iff (rst)
        (chan_tc & ~$past(chan_autoinit) & ~chan_mask) == '0); // R9

    AST_AUTO_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        !$past(io_wr && io_addr == PORT_W'(MASK_PORT)) |-> ((chan_tc & $past(chan_autoinit) & chan_mask) == '0)); // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.CH_N(CH_N), .PORT_W(PORT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .step          (step),
    .chan_mask     (chan_mask),
    .chan_tc       (chan_tc),
    .chan_dir      (chan_dir),
    .chan_autoinit (chan_autoinit),
    .chan_cascade  (chan_cascade),
    .hi_sel        (hi_sel)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [3:0] step = '0;
    logic [3:0] chan_mask, chan_tc, chan_autoinit, chan_cascade;
    logic [7:0] chan_dir;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    dma_chan_regs uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .step(step),
        .chan_mask(chan_mask), .chan_tc(chan_tc), .chan_dir(chan_dir),
        .chan_autoinit(chan_autoinit), .chan_cascade(chan_cascade)
    );

    typedef struct packed {
        logic       rd;
        logic [3:0] port;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    // Table walk covers R2 R3 R4 R5 (shared pointer, clear, readback order)
    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd10, 8'h00, 4'd3},
        '{1'b0, 4'd0,  8'h55, 4'd4},
        '{1'b0, 4'd0,  8'hAA, 4'd4},
        '{1'b1, 4'd0,  8'h55, 4'd4},
        '{1'b1, 4'd0,  8'hAA, 4'd4},
        '{1'b0, 4'd1,  8'h03, 4'd5},
        '{1'b0, 4'd1,  8'h00, 4'd5},
        '{1'b0, 4'd10, 8'h00, 4'd3},
        '{1'b1, 4'd3,  8'h00, 4'd2},
        '{1'b1, 4'd1,  8'h00, 4'd2},
        '{1'b0, 4'd10, 8'hFF, 4'd3},
        '{1'b1, 4'd1,  8'h03, 4'd5},
        '{1'b1, 4'd9,  8'h00, 4'd2},
        '{1'b1, 4'd1,  8'h00, 4'd2},
        '{1'b1, 4'd0,  8'h55, 4'd2},
        '{1'b1, 4'd0,  8'hAA, 4'd4}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #2 chk(16'(io_rdata), 16'(exp), tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        step = m;
        @(negedge clk);
        step = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(16'(chan_mask), 16'hF, "R1 mask");
        chk(16'(chan_dir), 16'h0, "R1 dir");
        chk(16'(chan_autoinit), 16'h0, "R1 autoinit");
        chk(16'(chan_cascade), 16'h0, "R1 cascade");
        bus_rd(4'd0, 8'h00, "R1 addr low");
        bus_rd(4'd0, 8'h00, "R1 addr high");

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd)
                bus_rd(VECS[i].port, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
            else
                bus_wr(VECS[i].port, VECS[i].data);
        end

        // Channel 1: step and terminal count without auto-initialise (R8, R9)
        bus_wr(4'd10, 8'h00);
        bus_wr(4'd2, 8'h10); bus_wr(4'd2, 8'h20);
        bus_wr(4'd3, 8'h01); bus_wr(4'd3, 8'h00);
        bus_wr(4'd9, 8'h45);
        chk(16'(chan_dir[3:2]), 16'h1, "R7 dir ch1");
        bus_wr(4'd8, 8'h01);
        chk(16'(chan_mask), 16'hD, "R6 unmask ch1");
        pulse(4'b0010);
        chk(16'(chan_tc), 16'h0, "R8 no tc");
        bus_rd(4'd2, 8'h11, "R8 addr lo"); bus_rd(4'd2, 8'h20, "R8 addr hi");
        bus_rd(4'd3, 8'h00, "R8 count lo"); bus_rd(4'd3, 8'h00, "R8 count hi");
        pulse(4'b0010);
        chk(16'(chan_tc), 16'h2, "R9 tc pulse");
        chk(16'(chan_mask[1]), 16'h1, "R9 self mask");
        bus_rd(4'd2, 8'h12, "R9 addr lo"); bus_rd(4'd2, 8'h20, "R9 addr hi");
        bus_rd(4'd3, 8'hFF, "R9 count lo"); bus_rd(4'd3, 8'hFF, "R9 count hi");
        pulse(4'b0010);
        chk(16'(chan_tc), 16'h0, "R8 masked tc");
        bus_rd(4'd2, 8'h12, "R8 masked addr"); bus_rd(4'd2, 8'h20, "R8 masked addr hi");

        // Channel 0: auto-initialise reload (R10)
        bus_wr(4'd10, 8'h00);
        bus_wr(4'd1, 8'h00); bus_wr(4'd1, 8'h00);
        bus_wr(4'd9, 8'h54);
        chk(16'(chan_autoinit), 16'h1, "R7 autoinit ch0");
        bus_wr(4'd8, 8'h00);
        chk(16'(chan_mask), 16'hE, "R6 unmask ch0");
        pulse(4'b0001);
        chk(16'(chan_tc), 16'h1, "R10 tc");
        chk(16'(chan_mask[0]), 16'h0, "R10 stays open");
        bus_rd(4'd0, 8'h55, "R10 addr lo"); bus_rd(4'd0, 8'hAA, "R10 addr hi");
        bus_rd(4'd1, 8'h00, "R10 count lo"); bus_rd(4'd1, 8'h00, "R10 count hi");
        bus_wr(4'd8, 8'h04);
        chk(16'(chan_mask[0]), 16'h1, "R6 remask ch0");

        // Channel 3: cascade ignores steps (R7)
        bus_wr(4'd9, 8'hC3);
        chk(16'(chan_cascade), 16'h8, "R7 cascade");
        bus_wr(4'd10, 8'h00);
        bus_wr(4'd6, 8'h00); bus_wr(4'd6, 8'h00);
        bus_wr(4'd7, 8'h05); bus_wr(4'd7, 8'h00);
        bus_wr(4'd8, 8'h03);
        pulse(4'b1000);
        chk(16'(chan_tc), 16'h0, "R7 cascade tc");
        bus_rd(4'd6, 8'h00, "R7 cascade addr"); bus_rd(4'd6, 8'h00, "R7 cascade addr hi");
        bus_rd(4'd7, 8'h05, "R7 cascade count"); bus_rd(4'd7, 8'h00, "R7 cascade count hi");

        // Channel 2: collisions (R11)
        bus_wr(4'd9, 8'h4A);
        chk(16'(chan_dir[5:4]), 16'h2, "R7 dir ch2");
        bus_wr(4'd10, 8'h00);
        bus_wr(4'd4, 8'h00); bus_wr(4'd4, 8'h00);
        bus_wr(4'd5, 8'h05); bus_wr(4'd5, 8'h00);
        bus_wr(4'd8, 8'h02);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 4'd4; io_wdata = 8'h77; step = 4'b0100;
        @(negedge clk);
        io_wr = 1'b0; step = '0;
        chk(16'(chan_tc), 16'h0, "R11 step dropped tc");
        bus_wr(4'd4, 8'h00);
        bus_wr(4'd10, 8'h00);
        bus_rd(4'd4, 8'h77, "R11 addr lo"); bus_rd(4'd4, 8'h00, "R11 addr hi");
        bus_rd(4'd5, 8'h05, "R11 count lo"); bus_rd(4'd5, 8'h00, "R11 count hi");
        bus_wr(4'd10, 8'h00);
        bus_wr(4'd5, 8'h00); bus_wr(4'd5, 8'h00);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 4'd8; io_wdata = 8'h02; step = 4'b0100;
        @(negedge clk);
        io_wr = 1'b0; step = '0;
        chk(16'(chan_tc), 16'h4, "R11 tc on collision");
        chk(16'(chan_mask[2]), 16'h1, "R11 self mask wins");

        // R1 reset again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(16'(chan_mask), 16'hF, "R1 mask after reset");
        chk(16'(chan_cascade), 16'h0, "R1 cascade after reset");
        bus_rd(4'd1, 8'h00, "R1 count after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule